// File: doc/BRIEF.md
# Pixel Nibble Output Serializer

This block takes 8-bit pixel and control bytes from an upstream readout stage and sends them over a 4-bit output bus. Each byte fills one pixel period of two system clocks. The high nibble goes out in the first clock and the low nibble in the second. Every bus value is registered, so the bus changes only on the rising clock edge. A `slot_msn` output tells downstream qualification logic which half of a byte is on the bus at the moment.

Bytes arrive through a valid/ready handshake. Ready is offered only in the clock that drives a low nibble, which is the byte boundary. A byte accepted there is driven during the next pixel period. A calibration control input makes the bus repeat the nibbles 9h and 6h without end, so that a receiver at the far end of a cable can search for its best sampling phase. The calibration input is sampled only at byte boundaries, so the nibble phase never slips. A high output-enable-bar input releases the bus to high impedance, and sequencing continues underneath.

Top module: `pix_nibble_serializer`

## Requirements
- R1: While reset is held, and until the first clock edge after its release, the bus drives 0h, `slot_msn` is 0 and `in_ready` equals `!cal_en`. The first cycle after reset counts as a low-nibble (boundary) slot.
- R2: `slot_msn` alternates on every rising clock edge out of reset: 1 marks the high-nibble slot and 0 marks the low-nibble slot.
- R3: `in_ready` is 1 exactly when `slot_msn` is 0 and `cal_en` is 0.
- R4: A byte accepted on an edge (`in_valid` and `in_ready` both 1) drives bits [7:4] in the cycle after that edge and bits [3:0] in the cycle after that.
- R5: When no byte is accepted at a boundary and `cal_en` is 0, the following pixel period drives 0h and then 0h.
- R6: When `cal_en` is 1 at a boundary edge, the following pixel period drives 9h and then 6h. A change of `cal_en` during a high-nibble slot has no effect on the low nibble that follows.
- R7: `in_valid` asserted while `in_ready` is 0 captures nothing. The next pixel period drives the idle or calibration pattern instead of that byte.
- R8: While `oe_bar` is 1 the bus is high impedance and `bus_drive` is 0. Sequencing still advances, so when `oe_bar` returns to 0 the bus shows the nibble scheduled for that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the bus updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream byte is valid |
| in_byte | input | 8 | Byte to serialize |
| in_ready | output | 1 | Byte accepted on this edge if `in_valid` is 1 |
| cal_en | input | 1 | Calibration pattern request, sampled at byte boundaries |
| oe_bar | input | 1 | Active-high bus disable (tristate) |
| nib_bus | output | 4 | Nibble output bus |
| bus_drive | output | 1 | 1 while the bus is actively driven |
| slot_msn | output | 1 | 1 while the high nibble is on the bus |

## Verification
The serializer is driven with directed bytes whose two nibbles differ, such as 3Ch and A5h, so a swapped or repeated half shows up at once. It is also driven with gaps between bytes, so idle zeros can be told apart from held data. `in_valid` is raised during high-nibble slots to show that capture happens only at the boundary. `cal_en` is toggled both at boundaries and in mid-pixel, which separates correct boundary sampling from an immediate switch. A long random run then mixes valid gaps, calibration bursts and bus disables, and a bench model of the two-slot sequence predicts every cycle.

// File: rtl/pns_pkg.sv
package pns_pkg;
  // Which half of the current byte is on the bus.
  typedef enum logic {
    SLOT_MSN = 1'b0,
    SLOT_LSN = 1'b1
  } slot_e;
endpackage

// File: rtl/pns_phase_gen.sv
module pns_phase_gen
  import pns_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output slot_e slot_o,
  output logic  boundary_o
);
  slot_e slot_q;

  // Reset lands in a low-nibble slot so the first edge is a byte boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= SLOT_LSN;
    else        slot_q <= (slot_q == SLOT_LSN) ? SLOT_MSN : SLOT_LSN;
  end

  assign slot_o     = slot_q;
  assign boundary_o = (slot_q == SLOT_LSN);

  // R2: slot alternates every clock
  p_slot_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (slot_q != $past(slot_q)));
endmodule

// File: rtl/pns_slot_sel.sv
module pns_slot_sel #(
  parameter int                  DATA_W = 8,
  parameter int                  NIB_W  = DATA_W / 2,
  parameter logic [NIB_W-1:0]    CAL_HI = 4'h9,
  parameter logic [NIB_W-1:0]    CAL_LO = 4'h6
) (
  input  logic              boundary,
  input  logic              cal_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  input  logic [NIB_W-1:0]  held_lo,
  output logic              in_ready,
  output logic              accept,
  output logic [NIB_W-1:0]  next_nib,
  output logic [NIB_W-1:0]  next_lo
);
  // Upper or lower half of a byte.
  function automatic logic [NIB_W-1:0] half_of(input logic [DATA_W-1:0] b, input logic upper);
    return upper ? b[DATA_W-1:NIB_W] : b[NIB_W-1:0];
  endfunction

  // Nibble chosen for a fresh pixel period: calibration, data or idle zero.
  function automatic logic [NIB_W-1:0] fresh_nib(input logic cal, input logic acc,
                                                 input logic [DATA_W-1:0] b, input logic upper);
    if (cal)      return upper ? CAL_HI : CAL_LO;
    else if (acc) return half_of(b, upper);
    else          return '0;
  endfunction

  assign in_ready = boundary && !cal_en;
  assign accept   = in_ready && in_valid;

  always_comb begin
    if (boundary) begin
      next_nib = fresh_nib(cal_en, accept, in_byte, 1'b1);
      next_lo  = fresh_nib(cal_en, accept, in_byte, 1'b0);
    end else begin
      next_nib = held_lo;
      next_lo  = held_lo;
    end
  end
endmodule

// File: rtl/pns_out_reg.sv
module pns_out_reg #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oe_bar,
  input  logic [NIB_W-1:0] next_nib,
  input  logic [NIB_W-1:0] next_lo,
  output logic [NIB_W-1:0] nib_q,
  output logic [NIB_W-1:0] lo_q,
  output logic             drive
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nib_q <= '0;
      lo_q  <= '0;
    end else begin
      nib_q <= next_nib;
      lo_q  <= next_lo;
    end
  end

  assign drive = !oe_bar;
endmodule

// File: rtl/pix_nibble_serializer.sv
module pix_nibble_serializer
  import pns_pkg::*;
#(
  parameter int                   DATA_W = 8,
  parameter logic [DATA_W/2-1:0]  CAL_HI = 4'h9,
  parameter logic [DATA_W/2-1:0]  CAL_LO = 4'h6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [DATA_W-1:0]     in_byte,
  output logic                  in_ready,
  input  logic                  cal_en,
  input  logic                  oe_bar,
  output logic [DATA_W/2-1:0]   nib_bus,
  output logic                  bus_drive,
  output logic                  slot_msn
);
  localparam int NIB_W = DATA_W / 2;

  slot_e            slot;
  logic             boundary;
  logic             accept;
  logic [NIB_W-1:0] next_nib, next_lo, nib_q, lo_q;

  pns_phase_gen u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_o     (slot),
    .boundary_o (boundary)
  );

  pns_slot_sel #(
    .DATA_W (DATA_W),
    .NIB_W  (NIB_W),
    .CAL_HI (CAL_HI),
    .CAL_LO (CAL_LO)
  ) u_sel (
    .boundary (boundary),
    .cal_en   (cal_en),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .held_lo  (lo_q),
    .in_ready (in_ready),
    .accept   (accept),
    .next_nib (next_nib),
    .next_lo  (next_lo)
  );

  pns_out_reg #(.NIB_W(NIB_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe_bar   (oe_bar),
    .next_nib (next_nib),
    .next_lo  (next_lo),
    .nib_q    (nib_q),
    .lo_q     (lo_q),
    .drive    (bus_drive)
  );

  assign slot_msn = (slot == SLOT_MSN);
  assign nib_bus  = bus_drive ? nib_q : 'z;

  // R3: ready only in a low-nibble slot
  p_ready_in_lsn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !slot_msn);

  // R4: accepted byte leaves high half then low half
  p_byte_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (nib_q == $past(in_byte[DATA_W-1:NIB_W])) ##1 (nib_q == $past(in_byte[NIB_W-1:0], 2)));

  // R5: no byte at a boundary gives two zero nibbles
  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !accept && !cal_en) |=> (nib_q == '0) ##1 (nib_q == '0));

  // R6: calibration sampled at the boundary gives the fixed pair
  p_cal_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && cal_en) |=> (nib_q == CAL_HI) ##1 (nib_q == CAL_LO));
endmodule

// File: tb/pix_nibble_serializer_tb_top.sv
module pix_nibble_serializer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic       cal_en = 1'b0;
  logic       oe_bar = 1'b0;
  logic       in_ready;
  logic [3:0] nib_bus;
  logic       bus_drive;
  logic       slot_msn;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Bench model state
  bit         m_lsn;
  logic [3:0] m_lo;
  string      m_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_nibble_serializer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .in_ready  (in_ready),
    .cal_en    (cal_en),
    .oe_bar    (oe_bar),
    .nib_bus   (nib_bus),
    .bus_drive (bus_drive),
    .slot_msn  (slot_msn)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected nibble for a new pixel period, restated from the requirements.
  function automatic logic [3:0] expect_nib(input bit cal, input bit got, input logic [7:0] b,
                                            input bit hi);
    if (cal) return hi ? 4'h9 : 4'h6;
    if (got) return hi ? b[7:4] : b[3:0];
    return 4'h0;
  endfunction

  // Entered and left at a falling edge.
  task automatic step(input bit v, input logic [7:0] b, input bit c, input bit oe,
                      input string force_tag);
    logic [3:0] e_nib;
    bit acc;
    in_valid = v; in_byte = b; cal_en = c; oe_bar = oe;
    #1;
    chk("R3", {7'd0, in_ready}, {7'd0, (m_lsn && !c)});
    if (m_lsn) begin
      acc   = v && !c;
      e_nib = expect_nib(c, acc, b, 1'b1);
      m_lo  = expect_nib(c, acc, b, 1'b0);
      m_tag = c ? "R6" : (acc ? "R4" : "R5");
      if (force_tag != "") m_tag = force_tag;
      m_lsn = 1'b0;
    end else begin
      e_nib = m_lo;
      m_lsn = 1'b1;
    end
    @(negedge clk);
    chk("R2", {7'd0, slot_msn}, {7'd0, !m_lsn});
    chk("R8", {7'd0, bus_drive}, {7'd0, !oe});
    if (!oe) chk(m_tag, {4'd0, nib_bus}, {4'd0, e_nib});
  endtask

  task automatic send_byte(input logic [7:0] b, input string tag);
    step(1'b1, b, 1'b0, 1'b0, tag);
    step(1'b0, 8'h00, 1'b0, 1'b0, "");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_lsn = 1'b1; m_lo = 4'h0; m_tag = "R1";
    repeat (3) @(negedge clk);
    // R1: values during reset
    chk("R1", {4'd0, nib_bus}, 8'h00);
    chk("R1", {7'd0, slot_msn}, 8'h00);
    rst_n = 1'b1;
    #1;
    chk("R1", {4'd0, nib_bus}, 8'h00);
    chk("R1", {7'd0, in_ready}, 8'h01);
    @(negedge clk);
    // First boundary: the model treats it as a fresh low slot.
    m_lsn = 1'b1;
    // Note: one edge passed with no byte, so the model steps it.
    m_lsn = 1'b0; m_lo = 4'h0;
    chk("R5", {4'd0, nib_bus}, 8'h00);
    step(1'b0, 8'h00, 1'b0, 1'b0, "R5");

    // R4: directed bytes with distinct halves
    send_byte(8'h3C, "R4");
    send_byte(8'hA5, "R4");
    step(1'b1, 8'hF0, 1'b0, 1'b0, "R4");
    step(1'b1, 8'h0F, 1'b0, 1'b0, "R7");

    // R7: valid raised only in a high-nibble slot, dropped at the boundary
    step(1'b0, 8'h00, 1'b0, 1'b0, "R7");
    step(1'b1, 8'hA5, 1'b0, 1'b0, "R7");
    step(1'b0, 8'h00, 1'b0, 1'b0, "R7");

    // R6: calibration for three pixel periods, valid byte held off
    repeat (3) begin
      step(1'b1, 8'h77, 1'b1, 1'b0, "R6");
      step(1'b1, 8'h77, 1'b1, 1'b0, "R6");
    end
    // R6: cal drops mid-pixel; the low nibble stays 6h
    step(1'b0, 8'h00, 1'b1, 1'b0, "R6");
    step(1'b0, 8'h00, 1'b0, 1'b0, "R6");
    // R6: cal raised mid-pixel after a data byte; the data low half still goes out
    step(1'b1, 8'hB2, 1'b0, 1'b0, "R4");
    step(1'b0, 8'h00, 1'b1, 1'b0, "R6");

    // R8: bus released for one pixel, sequencing continues
    step(1'b1, 8'hD4, 1'b0, 1'b1, "R8");
    step(1'b0, 8'h00, 1'b0, 1'b1, "R8");
    step(1'b1, 8'hE1, 1'b0, 1'b1, "R8");
    step(1'b0, 8'h00, 1'b0, 1'b0, "R8");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      bit v, c, o;
      v = ($urandom % 10) < 7;
      c = ($urandom % 20) == 0;
      o = ($urandom % 20) == 0;
      step(v, 8'($urandom), c, o, "");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule